// File: doc/BRIEF.md
# Packed Lane-Wise Integer Adder

This block adds two 256-bit vectors of packed integers, treating each vector as a row of independent lanes. An opcode byte picks the lane size (8, 16, 32 or 64 bits). A form flag separates the two-operand legacy encoding from the three-operand encoding. In the three-operand form a length bit picks between a 128-bit and a 256-bit operation. Each lane's sum is truncated to the lane size, and no carry crosses from one lane into the next.

The result is registered with one cycle of latency and qualified by an output-valid strobe. A separate flag reports whether the opcode was one of the four supported values, so a zero result from an unknown opcode can be told apart from a genuine zero sum. Operand fetch, register files and fault handling sit outside this block.

Top module: `packed_add_unit`

## Requirements
- R1: While rstN is low at a rising clock edge, outValid, resOk and outResult are all cleared to zero on that edge.
- R2: outValid is high on exactly the cycle after a cycle in which inValid was sampled high, and low otherwise.
- R3: No carry moves between lanes: a lane whose sum overflows leaves every neighbouring lane equal to its own independent sum.
- R4: Each lane keeps only the low lane-width bits of its sum, so an overflow wraps around silently.
- R5: The opcode picks the lane size: 8'hFC gives 8-bit lanes, 8'hFD 16-bit, 8'hFE 32-bit and 8'hD4 64-bit. Lane k covers result bits [k*w+w-1 : k*w], the same positions it has in the sources.
- R6: With threeOpForm low (legacy form), only bits [127:0] are summed and outResult[255:128] equals srcA[255:128], whatever the value of wideLen.
- R7: With threeOpForm high and wideLen high, all 256 bits are summed lane by lane.
- R8: With threeOpForm high and wideLen low, bits [127:0] are summed and outResult[255:128] is zero.
- R9: For any opcode other than the four in R5, outResult is zero and resOk is low; for the four supported opcodes resOk is high.
- R10: A cycle with inValid low leaves outResult and resOk unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Operands and controls are valid this cycle |
| srcA | input | 256 | First source vector; in legacy form it also supplies the upper half of the result |
| srcB | input | 256 | Second source vector |
| opByte | input | 8 | Opcode byte that selects the lane size |
| wideLen | input | 1 | Vector length in the three-operand form: 1 for 256 bits, 0 for 128 bits |
| threeOpForm | input | 1 | 1 selects the three-operand form, 0 the legacy form |
| outValid | output | 1 | outResult and resOk hold a new result |
| resOk | output | 1 | The opcode of the result was supported |
| outResult | output | 256 | Registered packed sum |

## Verification
A wrong lane boundary in the segmented carry chain shows up in the first result that carries out of a lane. It appears as a stray +1 in the lowest byte of the next lane, one cycle after the operands are presented. Operands of all ones plus one at each lane size expose this immediately. A wrong decode of the upper-half mode, or of the opcode, changes bits [255:128] or the resOk flag on that same first result. A stuck load strobe shows as an output that fails to hold, or fails to update, on the cycle after inValid changes.

// File: rtl/packed_add_pkg.sv
`timescale 1ns/1ps
package packed_add_pkg;
  localparam logic [7:0] OP_ADD8  = 8'hFC;
  localparam logic [7:0] OP_ADD16 = 8'hFD;
  localparam logic [7:0] OP_ADD32 = 8'hFE;
  localparam logic [7:0] OP_ADD64 = 8'hD4;

  localparam int LANE_KINDS = 4;

  // Strobes from control to datapath.
  // laneSel is one-hot: bit0 = 8-bit lanes, bit1 = 16, bit2 = 32, bit3 = 64.
  typedef struct packed {
    logic                  load;
    logic [LANE_KINDS-1:0] laneSel;
    logic                  fullWidth;
    logic                  keepUpper;
    logic                  supported;
  } addCtrl_t;
endpackage

// File: rtl/packed_add_ctrl.sv
`timescale 1ns/1ps
module packed_add_ctrl
  import packed_add_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] opByte,
  input  logic       wideLen,
  input  logic       threeOpForm,
  output addCtrl_t   ctrl,
  output logic       outValid,
  output logic       resOk
);
  always_comb begin
    ctrl = '0;
    ctrl.load = inValid;
    unique case (opByte)
      OP_ADD8:  ctrl.laneSel = 4'b0001;
      OP_ADD16: ctrl.laneSel = 4'b0010;
      OP_ADD32: ctrl.laneSel = 4'b0100;
      OP_ADD64: ctrl.laneSel = 4'b1000;
      default:  ctrl.laneSel = 4'b0000;
    endcase
    ctrl.supported = |ctrl.laneSel;
    ctrl.fullWidth = threeOpForm & wideLen;
    ctrl.keepUpper = ~threeOpForm;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      resOk    <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) resOk <= ctrl.supported;
    end
  end
endmodule

// File: rtl/packed_add_dp.sv
`timescale 1ns/1ps
module packed_add_dp
  import packed_add_pkg::*;
#(
  parameter int VEC_W  = 256,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  addCtrl_t         ctrl,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  output logic [VEC_W-1:0] outResult
);
  localparam int NUM_BYTES = VEC_W / BYTE_W;
  localparam int HALF_W    = VEC_W / 2;

  logic [NUM_BYTES-2:0] carry;
  logic [VEC_W-1:0]     laneSum;
  logic [VEC_W-1:0]     nextRes;

  // Byte-sliced carry chain; the chain is cut wherever a lane begins.
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    logic       cin;
    logic [BYTE_W-1:0] aB, bB;
    assign aB = srcA[b*BYTE_W +: BYTE_W];
    assign bB = srcB[b*BYTE_W +: BYTE_W];
    if (b == 0) begin : g_first
      assign cin = 1'b0;
    end else begin : g_rest
      localparam bit AT16 = (b % 2) == 0;
      localparam bit AT32 = (b % 4) == 0;
      localparam bit AT64 = (b % 8) == 0;
      logic laneStart;
      assign laneStart = ctrl.laneSel[0] | (ctrl.laneSel[1] & AT16)
                       | (ctrl.laneSel[2] & AT32) | (ctrl.laneSel[3] & AT64);
      assign cin = carry[b-1] & ~laneStart;
    end
    if (b < NUM_BYTES - 1) begin : g_mid
      assign {carry[b], laneSum[b*BYTE_W +: BYTE_W]} =
        {1'b0, aB} + {1'b0, bB} + {{BYTE_W{1'b0}}, cin};
    end else begin : g_top
      assign laneSum[b*BYTE_W +: BYTE_W] = aB + bB + {{(BYTE_W-1){1'b0}}, cin};
    end
  end

  always_comb begin
    nextRes = '0;
    if (ctrl.supported) begin
      nextRes[HALF_W-1:0] = laneSum[HALF_W-1:0];
      if (ctrl.fullWidth)
        nextRes[VEC_W-1:HALF_W] = laneSum[VEC_W-1:HALF_W];
      else if (ctrl.keepUpper)
        nextRes[VEC_W-1:HALF_W] = srcA[VEC_W-1:HALF_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          outResult <= '0;
    else if (ctrl.load) outResult <= nextRes;
  end
endmodule

// File: rtl/packed_add_unit.sv
`timescale 1ns/1ps
module packed_add_unit
  import packed_add_pkg::*;
#(
  parameter int VEC_W = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [VEC_W-1:0] srcA,
  input  logic [VEC_W-1:0] srcB,
  input  logic [7:0]       opByte,
  input  logic             wideLen,
  input  logic             threeOpForm,
  output logic             outValid,
  output logic             resOk,
  output logic [VEC_W-1:0] outResult
);
  addCtrl_t ctrl;

  packed_add_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opByte(opByte),
    .wideLen(wideLen), .threeOpForm(threeOpForm), .ctrl(ctrl),
    .outValid(outValid), .resOk(resOk)
  );

  packed_add_dp #(.VEC_W(VEC_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .srcA(srcA), .srcB(srcB),
    .outResult(outResult)
  );
endmodule

// File: rtl/packed_add_unit_chk.sv
`timescale 1ns/1ps
module packed_add_unit_chk #(
  parameter int VEC_W = 256
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [VEC_W-1:0] srcA,
  input logic [7:0]       opByte,
  input logic             wideLen,
  input logic             threeOpForm,
  input logic             outValid,
  input logic             resOk,
  input logic [VEC_W-1:0] outResult
);
  localparam int HALF_W = VEC_W / 2;
  logic opKnown;
  assign opKnown = (opByte == 8'hFC) || (opByte == 8'hFD)
                || (opByte == 8'hFE) || (opByte == 8'hD4);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  a_r9_unknown_zero: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !opKnown) |=> (!resOk && outResult == '0));
  a_r8_upper_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && threeOpForm && !wideLen) |=> (outResult[VEC_W-1:HALF_W] == '0));
  a_r6_upper_kept: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !threeOpForm && opKnown)
      |=> (outResult[VEC_W-1:HALF_W] == $past(srcA[VEC_W-1:HALF_W])));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outResult) && $stable(resOk)));
endmodule

bind packed_add_unit packed_add_unit_chk #(.VEC_W(VEC_W)) chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .srcA(srcA), .opByte(opByte),
  .wideLen(wideLen), .threeOpForm(threeOpForm), .outValid(outValid),
  .resOk(resOk), .outResult(outResult)
);

// File: tb/packed_add_unit_tb_top.sv
`timescale 1ns/1ps
module packed_add_unit_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [255:0] srcA = '0, srcB = '0;
  logic [7:0]   opByte = 8'h00;
  logic         wideLen = 1'b0, threeOpForm = 1'b0;
  logic         outValid, resOk;
  logic [255:0] outResult;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  packed_add_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcA(srcA), .srcB(srcB),
    .opByte(opByte), .wideLen(wideLen), .threeOpForm(threeOpForm),
    .outValid(outValid), .resOk(resOk), .outResult(outResult)
  );

  task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int laneOf(input logic [7:0] op);
    case (op)
      8'hFC: return 8;
      8'hFD: return 16;
      8'hFE: return 32;
      8'hD4: return 64;
      default: return 0;
    endcase
  endfunction

  function automatic logic [255:0] model(input logic [255:0] a, input logic [255:0] b,
                                         input logic [7:0] op, input logic len, input logic form);
    logic [255:0] full = '0;
    int w = laneOf(op);
    if (w == 0) return '0;
    for (int i = 0; i < 256 / w; i++) begin
      logic [63:0] x = 64'(a >> (i * w));
      logic [63:0] y = 64'(b >> (i * w));
      logic [63:0] s = x + y;
      for (int j = 0; j < w; j++) full[i * w + j] = s[j];
    end
    if (!form) return {a[255:128], full[127:0]};
    if (len) return full;
    return {128'b0, full[127:0]};
  endfunction

  // Presents one operation, checks result one cycle later.
  task automatic runOp(input string req, input logic [255:0] a, input logic [255:0] b,
                       input logic [7:0] op, input logic len, input logic form);
    @(negedge clk);
    srcA = a; srcB = b; opByte = op; wideLen = len; threeOpForm = form; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    chk(req, outResult, model(a, b, op, len, form));
    chk({req, " resOk"}, 256'(resOk), 256'(laneOf(op) != 0));
  endtask

  task automatic tReset();
    @(negedge clk);
    chk("R1 outValid", 256'(outValid), 0);
    chk("R1 resOk", 256'(resOk), 0);
    chk("R1 result", outResult, '0);
  endtask

  task automatic tLatency();
    @(negedge clk);
    srcA = '1; srcB = '1; opByte = 8'hFC; wideLen = 1; threeOpForm = 1; inValid = 1;
    @(negedge clk);
    inValid = 0;
    chk("R2 valid after one cycle", 256'(outValid), 1);
    @(negedge clk);
    chk("R2 valid drops", 256'(outValid), 0);
  endtask

  task automatic tCarryCut();
    logic [255:0] ones = '1;
    logic [255:0] one8 = {32{8'h01}};
    runOp("R3 R4 8-bit lanes", ones, one8, 8'hFC, 1, 1);
    runOp("R3 R4 16-bit lanes", ones, {16{16'h0001}}, 8'hFD, 1, 1);
    runOp("R3 R4 32-bit lanes", ones, {8{32'h1}}, 8'hFE, 1, 1);
    runOp("R3 R4 64-bit lanes", ones, {4{64'h1}}, 8'hD4, 1, 1);
    // Only lane 0 of each size overflows: neighbours must be unaffected
    runOp("R3 single overflow 8", {248'h0, 8'hFF}, {248'h0, 8'h02}, 8'hFC, 1, 1);
    chk("R3 lane1 of 8-bit stays zero", 256'(outResult[15:8]), 0);
    runOp("R3 single overflow 64", {192'h0, 64'hFFFF_FFFF_FFFF_FFFF}, {192'h0, 64'h5}, 8'hD4, 1, 1);
    chk("R4 wrapped 64-bit lane", 256'(outResult[127:0]), 256'(128'h4));
  endtask

  task automatic tLaneWidths();
    for (int k = 0; k < 4; k++) begin
      logic [7:0] op = (k == 0) ? 8'hFC : (k == 1) ? 8'hFD : (k == 2) ? 8'hFE : 8'hD4;
      logic [255:0] a, b;
      for (int r = 0; r < 8; r++) begin
        a[r*32 +: 32] = $urandom; b[r*32 +: 32] = $urandom;
      end
      runOp("R5 R7 width sweep", a, b, op, 1, 1);
    end
  endtask

  task automatic tLegacy();
    runOp("R6 legacy len0", {128'hA5A5, 128'hFFFF}, {128'h1234, 128'h0001}, 8'hFD, 0, 0);
    runOp("R6 legacy len1 ignored", {4{64'hDEAD_BEEF_0BAD_F00D}}, {4{64'h1111}}, 8'hFE, 1, 0);
  endtask

  task automatic tVex();
    runOp("R8 vex 128 upper zero", '1, '1, 8'hFC, 0, 1);
    runOp("R7 vex 256 full", {4{64'h8000_0000_0000_0001}}, {4{64'h8000_0000_0000_0001}}, 8'hD4, 1, 1);
  endtask

  task automatic tUnsupported();
    runOp("R9 unknown opcode", '1, '1, 8'hFB, 1, 1);
    chk("R9 valid still set", 256'(outValid), 1);
    runOp("R9 unknown legacy", '1, '1, 8'h00, 0, 0);
  endtask

  task automatic tHold();
    logic [255:0] kept;
    runOp("R10 setup", {8{32'h0102_0304}}, {8{32'h1}}, 8'hFE, 1, 1);
    kept = outResult;
    @(negedge clk);
    srcA = '1; srcB = '1; opByte = 8'h00; inValid = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 result held", outResult, kept);
    chk("R10 resOk held", 256'(resOk), 1);
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    tLatency();
    tCarryCut();
    tLaneWidths();
    tLegacy();
    tVex();
    tUnsupported();
    tHold();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule